// File: doc/BRIEF.md
# Big-Endian 64-Bit Bus Lane Steering

This block sits between an internal access port and a 64-bit external data bus that uses big-endian byte numbering: the byte at the lowest address of an 8-byte group travels on the most significant lane, bits 63 to 56. A request carries an address, a size (byte, word, longword or a 32-byte line), a direction and write data. The block then drives the bus address, the write data on the right lanes and an 8-bit lane strobe for each beat. On reads it returns the data right-justified.

Byte, word and longword requests take one beat. A line request takes four 64-bit beats, and the address steps by 8 on each beat. If the line request starts partway through a 32-byte line, the beats run to the end of the line and then wrap to its start. Each beat carries the 64-bit slice of the line that belongs to that beat's address. On line reads, each beat's data is stored at the slice position given by its address.

A request is taken only while the block is idle. Beats advance on a bus-ready input, and a one-cycle done pulse follows the last beat. A request whose address does not suit its size raises a one-cycle error flag and runs no beat.

Top module: `be64_lane_steer`

## Requirements
- R1: A byte access at offset k (address bits 2:0) drives write bits 7:0 on bus bits [63-8k : 56-8k] and sets strobe bit 7-k only. Strobe bit j covers bus bits [8j+7 : 8j].
- R2: A word access at an even offset k drives bits 15:8 on the lane of offset k and bits 7:0 on the lane of offset k+1. Strobe bits 7-k and 6-k are set.
- R3: A longword access at offset 0 drives bits 31:0 on bus bits 63:32 with strobe 8'hF0. At offset 4 it drives them on bus bits 31:0 with strobe 8'h0F. Bits 31:24 always go on the lowest-addressed lane.
- R4: A byte, word or longword access is one beat, with bus_addr equal to the request address. done is high for exactly the cycle after the edge at which that beat saw bus_ready.
- R5: A line access (size code 3) runs four beats with strobe 8'hFF. Each beat's address is 8 above the previous one, modulo the 32-byte line. Each beat drives write slice s = bus_addr[4:3], that is, line bits [64s+63 : 64s].
- R6: A line access that starts at a nonzero offset within the 32-byte line wraps to the line start after the beat at offset 24. It still runs exactly four beats and stays inside the same line.
- R7: On a byte, word or longword read, rdata holds the active lanes packed right-justified, with the lowest-addressed lane most significant. All higher rdata bits are zero. rdata is valid from the done cycle on.
- R8: On a line read, the data of each beat is stored at rdata bits [64s+63 : 64s], where s = bus_addr[4:3] of that beat.
- R9: A word at an odd address, a longword whose address bits 1:0 are nonzero, or a line whose address bits 2:0 are nonzero raises err for one cycle and drives no beat. Size codes: 0 byte, 1 word, 2 longword, 3 line.
- R10: While a transaction is in progress, req_ready is low and req_valid has no effect. The request presented meanwhile neither alters the current beats nor starts a transaction later.
- R11: After reset, req_ready is high and bus_active, done, err, bus_strb, bus_wdata and rdata are all zero.
- R12: A beat without bus_ready holds bus_active, bus_addr, bus_strb and bus_wdata unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 line |
| req_addr | input | AW (32) | Byte address of the request |
| req_wdata | input | 256 | Write data; bits 31:0 for single beats, the whole line for line writes |
| bus_active | output | 1 | A beat is on the bus |
| bus_addr | output | AW (32) | Address of the current beat |
| bus_strb | output | 8 | Lane strobe, bit j for bus bits [8j+7:8j] |
| bus_wdata | output | 64 | Steered write data, zero on reads and idle |
| bus_ready | input | 1 | Current beat completes at this edge |
| bus_rdata | input | 64 | Read data from the bus, sampled with bus_ready |
| done | output | 1 | One-cycle pulse after the last beat |
| err | output | 1 | One-cycle pulse for a misaligned request |
| rdata | output | 256 | Right-justified read data, or the gathered line |

## Verification
A request taken at one edge puts its first beat on the bus in the next cycle. The bus_ready edge of the last beat is followed one cycle later by done and valid rdata. A misaligned request shows err one cycle after it is taken. The bench drives inputs and samples outputs on the falling edge. It checks each beat's address, strobe and data in the half-cycle before the edge that consumes it, and checks done, err and rdata in the first falling edge after the edge that produces them. Stall cycles are inserted on purpose, and the bench confirms that the held beat does not move.

// File: rtl/be64_pkg.sv
// Shared types and helpers for the big-endian lane steering block.
// Assumes an 8-byte bus and 32-bit right-justified data for single-beat accesses.
package be64_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LINE = 2'd3
    } acc_size_e;

    // True when the low address bits do not suit the access size.
    function automatic logic misaligned(input acc_size_e sz, input logic [2:0] off);
        case (sz)
            SZ_WORD: return off[0];
            SZ_LONG: return |off[1:0];
            SZ_LINE: return |off;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/be64_lane_map.sv
// Combinational lane steering for one beat.
// It places right-justified write data on big-endian lanes, builds the lane strobe
// and packs the read lanes back to right-justified form.
// Assumes the offset is aligned to the size (the top rejects anything else).
module be64_lane_map
    import be64_pkg::*;
#(
    parameter int LANES = 8
) (
    input  acc_size_e              size_i,
    input  logic [$clog2(LANES)-1:0] off_i,
    input  logic [31:0]            small_i,
    input  logic [8*LANES-1:0]     line_i,
    input  logic [8*LANES-1:0]     rdata_i,
    output logic [LANES-1:0]       strb_o,
    output logic [8*LANES-1:0]     wdata_o,
    output logic [8*LANES-1:0]     rpack_o
);
    localparam int DW    = 8 * LANES;
    localparam int OFF_W = $clog2(LANES);
    localparam int CW    = OFF_W + 1;

    logic [CW-1:0]    nbytes;
    logic [CW-1:0]    shift_lanes;
    logic [LANES-1:0] lane_mask;
    logic [DW-1:0]    bit_mask;
    logic [DW-1:0]    small_ext;

    // Number of lanes the access covers.
    always_comb begin
        case (size_i)
            SZ_BYTE: nbytes = CW'(1);
            SZ_WORD: nbytes = CW'(2);
            SZ_LONG: nbytes = CW'(4);
            default: nbytes = CW'(LANES);
        endcase
    end

    // Distance of the access's least significant lane from lane 0.
    always_comb begin
        shift_lanes = CW'(LANES) - CW'(off_i) - nbytes;
    end

    // Lane and bit masks of the right-justified data.
    always_comb begin
        lane_mask = {LANES{1'b1}} >> (CW'(LANES) - nbytes);
        for (int j = 0; j < LANES; j++) begin
            bit_mask[8*j +: 8] = {8{lane_mask[j]}};
        end
    end

    // Strobe and write lanes: the lowest address lands on the top lane.
    always_comb begin
        small_ext = DW'(small_i) & bit_mask;
        strb_o    = lane_mask << shift_lanes;
        if (size_i == SZ_LINE) begin
            wdata_o = line_i;
        end else begin
            wdata_o = small_ext << {shift_lanes, 3'b000};
        end
    end

    // Read packing: bring the active lanes down to bit 0.
    always_comb begin
        rpack_o = (rdata_i >> {shift_lanes, 3'b000}) & bit_mask;
    end

endmodule

// File: rtl/be64_beat_seq.sv
// Beat sequencer: holds the current beat address, counts line beats,
// wraps the address within the line and pulses done after the last beat.
// Assumes start_i is raised only while active_o is low.
module be64_beat_seq #(
    parameter int AW         = 32,
    parameter int LINE_BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          start_line_i,
    input  logic          bus_ready_i,
    output logic          active_o,
    output logic [AW-1:0] beat_addr_o,
    output logic          last_o,
    output logic          done_o
);
    localparam int SLOT_W   = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
    localparam int LANE_LSB = 3;
    localparam int LINE_LSB = LANE_LSB + SLOT_W;

    logic              active_q;
    logic              line_q;
    logic [AW-1:0]     addr_q;
    logic [SLOT_W-1:0] cnt_q;
    logic              done_q;
    logic [AW-1:0]     next_addr;

    assign active_o    = active_q;
    assign beat_addr_o = addr_q;
    assign done_o      = done_q;
    assign last_o      = !line_q || (cnt_q == SLOT_W'(LINE_BEATS - 1));

    // Next beat address: step one slot, wrapping inside the line.
    always_comb begin
        next_addr = addr_q;
        next_addr[LINE_LSB-1:LANE_LSB] = addr_q[LINE_LSB-1:LANE_LSB] + SLOT_W'(1);
    end

    // Transaction state: start, advance on ready, finish after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            line_q   <= 1'b0;
            addr_q   <= '0;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                active_q <= 1'b1;
                line_q   <= start_line_i;
                addr_q   <= start_addr_i;
                cnt_q    <= '0;
            end else if (active_q && bus_ready_i) begin
                if (last_o) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    cnt_q  <= cnt_q + SLOT_W'(1);
                    addr_q <= next_addr;
                end
            end
        end
    end

    // A beat without ready stays on the bus unchanged.
    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        active_q && !bus_ready_i |=> active_q && $stable(addr_q));

    // done only follows the ready edge of a final beat.
    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(active_q && bus_ready_i && last_o));

    // Consecutive beats of a line stay inside one line.
    assert_wrap_in_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active_q && bus_ready_i && !last_o |=>
            active_q && (addr_q[AW-1:LINE_LSB] == $past(addr_q[AW-1:LINE_LSB])));

endmodule

// File: rtl/be64_line_gather.sv
// Read data register: keeps the packed result of a single-beat read,
// or assembles a line from beats placed by their address slot.
// Assumes clear_i comes when a transaction starts, so bytes from an older read do not remain.
module be64_line_gather #(
    parameter int DW         = 64,
    parameter int LINE_BEATS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     capture_i,
    input  logic                     line_i,
    input  logic [((LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1)-1:0] slot_i,
    input  logic [DW-1:0]            rdata_i,
    input  logic [DW-1:0]            rpack_i,
    output logic [DW*LINE_BEATS-1:0] rdata_o
);
    localparam int LW = DW * LINE_BEATS;

    logic [LW-1:0] rdata_q;

    assign rdata_o = rdata_q;

    // Store the read beat: a line slice at its slot, or the packed value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (clear_i) begin
            rdata_q <= '0;
        end else if (capture_i) begin
            if (line_i) begin
                rdata_q[int'(slot_i)*DW +: DW] <= rdata_i;
            end else begin
                rdata_q <= LW'(rpack_i);
            end
        end
    end

endmodule

// File: rtl/be64_lane_steer.sv
// Top of the big-endian 64-bit lane steering block.
// It takes one request at a time, rejects misaligned ones, sequences the beats
// and joins the lane map, the beat sequencer and the read register.
// Assumes a 64-bit bus; LINE_BEATS sets the line length in 8-byte beats.
module be64_lane_steer
    import be64_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BEATS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [1:0]                 req_size,
    input  logic [AW-1:0]              req_addr,
    input  logic [64*LINE_BEATS-1:0]   req_wdata,
    output logic                       bus_active,
    output logic [AW-1:0]              bus_addr,
    output logic [7:0]                 bus_strb,
    output logic [63:0]                bus_wdata,
    input  logic                       bus_ready,
    input  logic [63:0]                bus_rdata,
    output logic                       done,
    output logic                       err,
    output logic [64*LINE_BEATS-1:0]   rdata
);
    localparam int LANES    = 8;
    localparam int DW       = 8 * LANES;
    localparam int LW       = DW * LINE_BEATS;
    localparam int SLOT_W   = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
    localparam int LINE_LSB = 3 + SLOT_W;

    acc_size_e         size_in;
    acc_size_e         size_q;
    logic              write_q;
    logic [LW-1:0]     wdata_q;
    logic              err_q;
    logic              accept;
    logic              bad;
    logic              start;
    logic              seq_active;
    logic              seq_last;
    logic              seq_done;
    logic [AW-1:0]     beat_addr;
    logic [SLOT_W-1:0] slot;
    logic [DW-1:0]     line_slice;
    logic [LANES-1:0]  map_strb;
    logic [DW-1:0]     map_wdata;
    logic [DW-1:0]     map_rpack;

    // Request decode: accept only while idle, and screen alignment.
    always_comb begin
        size_in = acc_size_e'(req_size);
        accept  = req_valid && !seq_active;
        bad     = misaligned(size_in, req_addr[2:0]);
        start   = accept && !bad;
    end

    // Latch the request attributes for the duration of the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q  <= SZ_BYTE;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (start) begin
            size_q  <= size_in;
            write_q <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // One-cycle error pulse for a rejected request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= accept && bad;
        end
    end

    be64_beat_seq #(
        .AW         (AW),
        .LINE_BEATS (LINE_BEATS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .start_addr_i (req_addr),
        .start_line_i (size_in == SZ_LINE),
        .bus_ready_i  (bus_ready),
        .active_o     (seq_active),
        .beat_addr_o  (beat_addr),
        .last_o       (seq_last),
        .done_o       (seq_done)
    );

    // Slice of the write line that belongs to the current beat address.
    always_comb begin
        slot       = beat_addr[LINE_LSB-1:3];
        line_slice = wdata_q[int'(slot)*DW +: DW];
    end

    be64_lane_map #(
        .LANES (LANES)
    ) u_map (
        .size_i  (size_q),
        .off_i   (beat_addr[2:0]),
        .small_i (wdata_q[31:0]),
        .line_i  (line_slice),
        .rdata_i (bus_rdata),
        .strb_o  (map_strb),
        .wdata_o (map_wdata),
        .rpack_o (map_rpack)
    );

    be64_line_gather #(
        .DW         (DW),
        .LINE_BEATS (LINE_BEATS)
    ) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start),
        .capture_i (seq_active && bus_ready && !write_q),
        .line_i    (size_q == SZ_LINE),
        .slot_i    (slot),
        .rdata_i   (bus_rdata),
        .rpack_i   (map_rpack),
        .rdata_o   (rdata)
    );

    // Bus-side outputs, quiet while idle.
    always_comb begin
        req_ready  = !seq_active;
        bus_active = seq_active;
        bus_addr   = beat_addr;
        bus_strb   = seq_active ? map_strb : '0;
        bus_wdata  = (seq_active && write_q) ? map_wdata : '0;
        done       = seq_done;
        err        = err_q;
    end

    // A rejected request never puts a beat on the bus.
    assert_err_no_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bus_active);

    // Byte beats drive exactly one lane.
    assert_byte_one_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && size_q == SZ_BYTE |-> $countones(bus_strb) == 1);

    // Word beats drive two lanes, longword beats four.
    assert_word_long_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && size_q != SZ_BYTE && size_q != SZ_LINE |->
            $countones(bus_strb) == ((size_q == SZ_WORD) ? 2 : 4));

    // Line beats drive every lane.
    assert_line_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && size_q == SZ_LINE |-> bus_strb == 8'hFF);

    // A new transaction cannot begin while one is running.
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && !(bus_ready && seq_last) |=> bus_active && $stable(size_q));

endmodule

// File: tb/be64_lane_steer_test.sv
module be64_lane_steer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [1:0]   req_size = 2'd0;
    logic [31:0]  req_addr = '0;
    logic [255:0] req_wdata = '0;
    logic         bus_active;
    logic [31:0]  bus_addr;
    logic [7:0]   bus_strb;
    logic [63:0]  bus_wdata;
    logic         bus_ready = 1'b0;
    logic [63:0]  bus_rdata = '0;
    logic         done;
    logic         err;
    logic [255:0] rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    be64_lane_steer uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .bus_active(bus_active), .bus_addr(bus_addr), .bus_strb(bus_strb),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .done(done), .err(err), .rdata(rdata)
    );

    // Single-beat write vectors: size, offset, expected strobe, expected bus data.
    // Write data is always 32'hA1B2C3D4.
    localparam logic [76:0] WVEC [8] = '{
        {2'd0, 3'd0, 8'h80, 64'hD400_0000_0000_0000},
        {2'd0, 3'd5, 8'h04, 64'h0000_0000_00D4_0000},
        {2'd0, 3'd7, 8'h01, 64'h0000_0000_0000_00D4},
        {2'd1, 3'd0, 8'hC0, 64'hC3D4_0000_0000_0000},
        {2'd1, 3'd2, 8'h30, 64'h0000_C3D4_0000_0000},
        {2'd1, 3'd6, 8'h03, 64'h0000_0000_0000_C3D4},
        {2'd2, 3'd0, 8'hF0, 64'hA1B2_C3D4_0000_0000},
        {2'd2, 3'd4, 8'h0F, 64'h0000_0000_A1B2_C3D4}
    };

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] wslice(input int i);
        return {32'hA5A5_0000 + 32'(i), 32'h5A5A_0000 + 32'(i)};
    endfunction

    function automatic logic [63:0] rslice(input int i);
        return {32'hCAFE_0000 + 32'(i), 32'h00BE_EF00 + 32'(i)};
    endfunction

    // One single-beat transaction; checks the beat and the done pulse.
    task automatic single(input logic wr, input logic [1:0] sz, input logic [31:0] addr,
                          input logic [63:0] rd, input logic [7:0] es,
                          input logic [63:0] ew, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr;
        req_wdata = {224'b0, 32'hA1B2C3D4};
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " beat active R4"}, 256'(bus_active), 256'(1));
        chk({tag, " addr R4"}, 256'(bus_addr), 256'(addr));
        chk({tag, " strobe"}, 256'(bus_strb), 256'(es));
        chk({tag, " data"}, 256'(bus_wdata), 256'(ew));
        bus_ready = 1'b1; bus_rdata = rd;
        @(negedge clk);
        bus_ready = 1'b0;
        chk({tag, " done R4"}, 256'(done), 256'(1));
        chk({tag, " one beat R4"}, 256'(bus_active), 256'(0));
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [255:0] line_w;
        logic [255:0] line_r;
        logic [31:0]  base;
        int off;
        int s;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 req_ready", 256'(req_ready), 256'(1));
        chk("R11 bus_active", 256'(bus_active), 256'(0));
        chk("R11 done", 256'(done), 256'(0));
        chk("R11 err", 256'(err), 256'(0));
        chk("R11 strobe", 256'(bus_strb), 256'(0));
        chk("R11 wdata", 256'(bus_wdata), 256'(0));
        chk("R11 rdata", rdata, 256'(0));

        // R1 R2 R3 write lane placement from the vector table
        for (int v = 0; v < 8; v++) begin
            single(1'b1, WVEC[v][76:75], 32'h1000_0040 + 32'(WVEC[v][74:72]), 64'h0,
                   WVEC[v][71:64], WVEC[v][63:0],
                   (WVEC[v][76:75] == 2'd0) ? "R1 byte" :
                   (WVEC[v][76:75] == 2'd1) ? "R2 word" : "R3 long");
        end

        // R7 reads packed right-justified
        single(1'b0, 2'd1, 32'h1000_0042, 64'h0011_2233_4455_6677, 8'h30, 64'h0, "R7 word read");
        chk("R7 word read value", rdata, 256'(16'h2233));
        single(1'b0, 2'd0, 32'h1000_0047, 64'h0011_2233_4455_6677, 8'h01, 64'h0, "R7 byte read");
        chk("R7 byte read value", rdata, 256'(8'h77));
        single(1'b0, 2'd2, 32'h1000_0044, 64'h0011_2233_4455_6677, 8'h0F, 64'h0, "R7 long read");
        chk("R7 long read value", rdata, 256'(32'h4455_6677));
        single(1'b0, 2'd0, 32'h1000_0040, 64'h8811_2233_4455_6677, 8'h80, 64'h0, "R7 byte0 read");
        chk("R7 byte0 read value", rdata, 256'(8'h88));

        // R5 R6 R12 wrapped line write starting at line offset 16, with one stall
        base = 32'h2000_0100;
        for (int i = 0; i < 4; i++) line_w[64*i +: 64] = wslice(i);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd3; req_addr = base + 32'd16;
        req_wdata = line_w;
        @(negedge clk);
        req_valid = 1'b0;
        for (int j = 0; j < 4; j++) begin
            off = (16 + 8*j) % 32;
            s = off / 8;
            if (j == 1) begin
                bus_ready = 1'b0;
                @(negedge clk);
                chk("R12 stalled beat active", 256'(bus_active), 256'(1));
                chk("R12 stalled beat addr", 256'(bus_addr), 256'(base + 32'(off)));
                chk("R12 stalled beat data", 256'(bus_wdata), 256'(wslice(s)));
            end
            chk("R6 line write addr", 256'(bus_addr), 256'(base + 32'(off)));
            chk("R5 line write strobe", 256'(bus_strb), 256'(8'hFF));
            chk("R5 line write slice", 256'(bus_wdata), 256'(wslice(s)));
            bus_ready = 1'b1;
            @(negedge clk);
        end
        bus_ready = 1'b0;
        chk("R6 line write done after four", 256'(done), 256'(1));
        chk("R6 line write idle", 256'(bus_active), 256'(0));

        // R5 aligned line write
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd3; req_addr = base;
        @(negedge clk);
        req_valid = 1'b0;
        for (int j = 0; j < 4; j++) begin
            chk("R5 aligned line addr", 256'(bus_addr), 256'(base + 32'(8*j)));
            chk("R5 aligned line slice", 256'(bus_wdata), 256'(wslice(j)));
            bus_ready = 1'b1;
            @(negedge clk);
        end
        bus_ready = 1'b0;
        chk("R5 aligned line done", 256'(done), 256'(1));

        // R8 wrapped line read starting at line offset 24
        for (int i = 0; i < 4; i++) line_r[64*i +: 64] = rslice(i);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'd3; req_addr = base + 32'd24;
        @(negedge clk);
        req_valid = 1'b0;
        for (int j = 0; j < 4; j++) begin
            off = (24 + 8*j) % 32;
            chk("R8 line read addr", 256'(bus_addr), 256'(base + 32'(off)));
            chk("R8 read drives no data", 256'(bus_wdata), 256'(0));
            bus_ready = 1'b1; bus_rdata = rslice(off / 8);
            @(negedge clk);
        end
        bus_ready = 1'b0;
        chk("R8 line read done", 256'(done), 256'(1));
        chk("R8 line read gathered", rdata, line_r);

        // R9 misaligned requests
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd1; req_addr = 32'h1000_0041;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 odd word err", 256'(err), 256'(1));
        chk("R9 odd word no beat", 256'(bus_active), 256'(0));
        @(negedge clk);
        chk("R9 err one cycle", 256'(err), 256'(0));
        chk("R9 still no beat", 256'(bus_active), 256'(0));
        req_valid = 1'b1; req_size = 2'd2; req_addr = 32'h1000_0042;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 long err", 256'(err), 256'(1));
        chk("R9 long no beat", 256'(bus_active), 256'(0));
        @(negedge clk);
        req_valid = 1'b1; req_size = 2'd3; req_addr = 32'h1000_0044;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 line err", 256'(err), 256'(1));
        chk("R9 line no beat", 256'(bus_active), 256'(0));

        // R10 requests ignored while busy
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = 32'h1000_0043;
        req_wdata = {224'b0, 32'hA1B2C3D4};
        @(negedge clk);
        req_size = 2'd1; req_addr = 32'h1000_0060;
        chk("R10 busy not ready", 256'(req_ready), 256'(0));
        @(negedge clk);
        chk("R10 beat kept addr", 256'(bus_addr), 256'(32'h1000_0043));
        chk("R10 beat kept strobe", 256'(bus_strb), 256'(8'h10));
        req_valid = 1'b0; bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        chk("R10 done", 256'(done), 256'(1));
        @(negedge clk);
        chk("R10 no late start", 256'(bus_active), 256'(0));
        chk("R10 idle ready", 256'(req_ready), 256'(1));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule